// File: doc/BRIEF.md
# ALIGN Primitive Insertion Scheduler

This block sits on the transmit side of a serial link layer and decides, slot by slot, what goes out on the wire. One DWord leaves each clock cycle. That DWord is an ALIGN primitive, a data word taken from an upstream source, or an idle filler word when the source has nothing to send. The block counts every outgoing slot. When the programmed interval has run out, it sends a burst of consecutive ALIGN primitives in place of data.

The upstream source uses a valid/ready handshake. Ready is held low for the whole of an ALIGN burst, so no data word is lost or repeated. Two settings control the schedule: an 8-bit spacing value (`rate`) and a flag (`quad_align`) that stretches each burst from two primitives to four. Both settings are captured only in the first slot of a burst. A burst that has already started always runs to its full length, and the gap that follows it uses the spacing value captured with it.

Supported settings are `rate` of 3 or more when `quad_align` is low, and `rate` of 5 or more when it is high. The value a control register would reset to is all ones, which gives 254 slots between bursts.

Top module: `align_sched`

## Requirements
- R1: While reset is asserted, and in the first slot after reset is released, the block emits an ALIGN primitive: `tx_align` is 1, `tx_dword` equals the parameter `ALIGN_WORD`, and `up_ready` is 0.
- R2: Between the last ALIGN of one burst and the first ALIGN of the next, exactly `rate - 1` non-ALIGN slots are emitted. `rate` here is the value captured in the first slot of the earlier burst. With `rate` = 255 this gives 254 slots.
- R3: When `quad_align` is 0 in the first slot of a burst, the burst is exactly two consecutive ALIGN slots.
- R4: When `quad_align` is 1 in the first slot of a burst, the burst is exactly four consecutive ALIGN slots.
- R5: `up_ready` is 0 in every ALIGN slot and 1 in every other slot. No upstream word is taken while `up_ready` is 0.
- R6: A non-ALIGN slot with `up_valid` low is an idle slot: `tx_align` = 0, `tx_data_valid` = 0, `tx_dword` = 0. Idle slots count toward the R2 spacing exactly as data slots do.
- R7: Changes to `rate` or `quad_align` after the first slot of a burst do not alter the length of that burst or of the gap that follows it.
- R8: A non-ALIGN slot with `up_valid` high is a data slot: `tx_data_valid` = 1, `tx_align` = 0, and `tx_dword` equals `up_data`. Accepted words leave in source order, each exactly once.
- R9: `tx_align` and `tx_data_valid` are never 1 in the same slot, and no ALIGN burst is longer than four slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one DWord slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate | input | 8 | Spacing setting; a gap holds rate − 1 slots |
| quad_align | input | 1 | 1 selects four ALIGNs per burst, 0 selects two |
| up_data | input | 32 | Upstream data word |
| up_valid | input | 1 | Upstream word available |
| up_ready | output | 1 | Block takes the upstream word this cycle |
| tx_dword | output | 32 | DWord sent in this slot |
| tx_align | output | 1 | This slot carries an ALIGN primitive |
| tx_data_valid | output | 1 | This slot carries an upstream data word |

## Verification
The bench builds the block with its default parameters: 32-bit words, an 8-bit spacing field and a distinct non-zero ALIGN word. Because the spacing field is 8 bits wide, the all-ones case of 254 slots can be driven directly, alongside the smallest legal gaps of 2 and 4 slots. The bench also flips the burst-length flag and the spacing value on every cycle, which makes sure that the settings are captured only at burst start. Long stretches with no upstream data show whether idle slots still advance the spacing count.

// File: rtl/align_sched_pkg.sv
package align_sched_pkg;
  typedef enum logic {
    PH_BURST = 1'b0,
    PH_GAP   = 1'b1
  } sched_phase_e;

  localparam int unsigned BURST_SHORT = 2;
  localparam int unsigned BURST_LONG  = 4;
endpackage

// File: rtl/align_sched_ctrl.sv
module align_sched_ctrl
  import align_sched_pkg::*;
#(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              quad_align,
  output logic              in_burst
);
  localparam logic [RATE_W-1:0] SLOT_SHORT_LAST = RATE_W'(BURST_SHORT - 1);
  localparam logic [RATE_W-1:0] SLOT_LONG_LAST  = RATE_W'(BURST_LONG - 1);
  localparam logic [RATE_W-1:0] GAP_BIAS        = RATE_W'(2);

  sched_phase_e      phase_q, phase_d;
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              quad_q, quad_d;
  logic              burst_start;
  logic              quad_eff;
  logic              burst_last;

  always_comb begin
    burst_start = (phase_q == PH_BURST) && (cnt_q == '0);
    quad_eff    = burst_start ? quad_align : quad_q;
    burst_last  = quad_eff ? (cnt_q == SLOT_LONG_LAST) : (cnt_q == SLOT_SHORT_LAST);
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rate_d  = rate_q;
    quad_d  = quad_q;
    if (burst_start) begin
      rate_d = rate;
      quad_d = quad_align;
    end
    case (phase_q)
      PH_BURST: begin
        if (burst_last) begin
          phase_d = PH_GAP;
          cnt_d   = rate_q - GAP_BIAS;
        end else begin
          cnt_d = cnt_q + RATE_W'(1);
        end
      end
      default: begin
        if (cnt_q == '0) begin
          phase_d = PH_BURST;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - RATE_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_BURST;
      cnt_q   <= '0;
      rate_q  <= '1;
      quad_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rate_q  <= rate_d;
      quad_q  <= quad_d;
    end
  end

  assign in_burst = (phase_q == PH_BURST);
endmodule

// File: rtl/align_sched_mux.sv
module align_sched_mux #(
  parameter int unsigned          DATA_W     = 32,
  parameter logic [DATA_W-1:0]    ALIGN_WORD = '1
) (
  input  logic              in_burst,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_valid,
  output logic              up_ready,
  output logic [DATA_W-1:0] tx_dword,
  output logic              tx_align,
  output logic              tx_data_valid
);
  always_comb begin
    up_ready      = !in_burst;
    tx_align      = in_burst;
    tx_data_valid = !in_burst && up_valid;
    if (in_burst)          tx_dword = ALIGN_WORD;
    else if (up_valid)     tx_dword = up_data;
    else                   tx_dword = '0;
  end
endmodule

// File: rtl/align_sched.sv
module align_sched #(
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       RATE_W     = 8,
  parameter logic [DATA_W-1:0] ALIGN_WORD = 32'h7B4A_4ABC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              quad_align,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_valid,
  output logic              up_ready,
  output logic [DATA_W-1:0] tx_dword,
  output logic              tx_align,
  output logic              tx_data_valid
);
  logic in_burst;

  align_sched_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate       (rate),
    .quad_align (quad_align),
    .in_burst   (in_burst)
  );

  align_sched_mux #(.DATA_W(DATA_W), .ALIGN_WORD(ALIGN_WORD)) u_mux (
    .in_burst      (in_burst),
    .up_data       (up_data),
    .up_valid      (up_valid),
    .up_ready      (up_ready),
    .tx_dword      (tx_dword),
    .tx_align      (tx_align),
    .tx_data_valid (tx_data_valid)
  );
endmodule

// File: rtl/align_sched_chk.sv
module align_sched_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_ready,
  input logic              up_valid,
  input logic [DATA_W-1:0] tx_dword,
  input logic              tx_align,
  input logic              tx_data_valid
);
  logic       started_q;
  logic [2:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      run_q     <= '0;
    end else begin
      started_q <= 1'b1;
      if (tx_align) run_q <= (run_q == 3'd7) ? run_q : run_q + 3'd1;
      else          run_q <= '0;
    end
  end

  // R1
  first_slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |-> tx_align);

  // R5
  ready_low_in_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_align |-> !up_ready);

  // R3
  burst_min_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_align) |-> ##1 tx_align);

  // R2
  gap_min_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_align) |=> !tx_align);

  // R9
  exclusive_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_align && tx_data_valid));

  // R9
  burst_max_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 3'd4);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ready && !up_valid) |-> (tx_dword == '0 && !tx_data_valid));
endmodule

bind align_sched align_sched_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .up_ready      (up_ready),
  .up_valid      (up_valid),
  .tx_dword      (tx_dword),
  .tx_align      (tx_align),
  .tx_data_valid (tx_data_valid)
);

// File: tb/align_sched_test.sv
`timescale 1ns/1ps
module align_sched_test;
  localparam logic [31:0] AW = 32'h7B4A_4ABC;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rate = 8'hFF;
  logic        quad_align = 1'b0;
  logic [31:0] up_data;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic [31:0] tx_dword;
  logic        tx_align;
  logic        tx_data_valid;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] src_word = 32'h1000_0000;
  assign up_data = src_word;

  bit m_align = 1'b1;
  int m_idx = 0;
  int m_gap = 0;
  bit m_quad = 1'b0;
  int m_rate = 255;
  int gap_seen = 0;
  bit first_slot = 1'b1;
  bit seen_burst = 1'b0;

  align_sched uut (
    .clk(clk), .rst_n(rst_n), .rate(rate), .quad_align(quad_align),
    .up_data(up_data), .up_valid(up_valid), .up_ready(up_ready),
    .tx_dword(tx_dword), .tx_align(tx_align), .tx_data_valid(tx_data_valid)
  );

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic int exp_gap(int r);
    return r - 1;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      check("R1 reset align", {29'd0, tx_align, up_ready, tx_data_valid}, 32'd4);
      check("R1 reset word", tx_dword, AW);
    end else if (m_align) begin
      bit q;
      string tag;
      q = (m_idx == 0) ? quad_align : m_quad;
      tag = first_slot ? "R1" : ((m_idx != 0 && quad_align != m_quad) ? "R7" : (q ? "R4" : "R3"));
      if (m_idx == 0 && seen_burst)
        check("R2 gap length", gap_seen, exp_gap(m_rate));
      if (m_idx == 0) begin
        m_quad = quad_align;
        m_rate = int'(rate);
      end
      check({tag, " align slot"}, {29'd0, tx_align, up_ready, tx_data_valid}, 32'd4);
      check({tag, " align word"}, tx_dword, AW);
      first_slot = 1'b0;
      m_idx++;
      if (m_idx == (q ? 4 : 2)) begin
        m_align = 1'b0;
        m_gap = exp_gap(m_rate);
        gap_seen = 0;
        seen_burst = 1'b1;
      end
    end else begin
      if (up_valid) begin
        check("R8 data slot", {29'd0, tx_align, up_ready, tx_data_valid}, 32'd3);
        check("R8 data word", tx_dword, src_word);
        src_word = src_word + 32'd1;
      end else begin
        check("R6 idle slot", {29'd0, tx_align, up_ready, tx_data_valid}, 32'd2);
        check("R6 idle word", tx_dword, 32'd0);
      end
      gap_seen++;
      m_gap--;
      if (m_gap == 0) begin
        m_align = 1'b1;
        m_idx = 0;
      end
    end
  end

  // R5: nothing taken while ready is low is covered by the source order check in R8.
  task automatic drive(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      case (mode)
        0: begin
          quad_align = $urandom % 2;
          rate = quad_align ? 8'(5 + $urandom % 12) : 8'(3 + $urandom % 14);
          up_valid = ($urandom % 4) != 0;
        end
        1: begin
          quad_align = ~quad_align;
          rate = 8'(6 + $urandom % 3);
          up_valid = $urandom % 2;
        end
        2: up_valid = 1'b0;
        default: up_valid = 1'b1;
      endcase
    end
  endtask

  initial begin
    #(LIMIT * 4);
    fails++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    up_valid = 1'b1;
    drive(1200, 3);
    rate = 8'd3; quad_align = 1'b0;
    drive(300, 3);
    rate = 8'd5; quad_align = 1'b1;
    drive(300, 3);
    rate = 8'd40; quad_align = 1'b0;
    drive(400, 2);
    drive(3000, 1);
    drive(20000, 0);
    rate = 8'hFF; quad_align = 1'b1;
    drive(800, 2);
    check("R8 words consumed", 32'(src_word != 32'h1000_0000), 32'd1);
    finish_run();
  end
endmodule